// File: doc/BRIEF.md
# SIMD Pixel Processing Cell

This block is one 8-bit cell of a two-dimensional processor array in which every cell receives the same instruction word on the same clock edge and executes it in parallel. The cell holds seven general-purpose registers and an accumulator. It has a subtract-only arithmetic unit that also performs addition, and three status flags: zero, carry and propagate. A flag-based condition field in each instruction lets individual cells skip an instruction, which gives them a degree of local autonomy.

Every instruction is a register transfer in three steps:

1. A source register is placed on the cell's read bus.
2. A bus selector places one value on the write bus: the cell's own read bus, the global input bus, or the read bus of the north, east, south or west neighbour.
3. The write bus is loaded into a destination: a register, the accumulator through the arithmetic unit, a shifted register, or the propagate flag.

The read bus leaves the cell combinationally, so a neighbour can load it within the same instruction. The low-numbered registers can load the write bus shifted one place left or right, with a carry-in bit taken from the instruction. Shift-and-add multiplication and shift-and-subtract division are built from this step.

Top module: `pxl_cell`

## Requirements
- R1: While `rst` is high at a clock edge, all registers, the accumulator, `flag_out` and `gbus_out` become zero.
- R2: `lbus_out` combinationally shows the register selected by `instr[2:0]`, where codes 0 to 6 select registers R0 to R6 and code 7 selects the accumulator.
- R3: Opcode 1 (move, `instr[8:6]`) loads the write bus into the register numbered by `instr[11:9]`; destination code 7 writes nothing. A move leaves the flags unchanged.
- R4: The write-bus source `instr[5:3]` is decoded as follows: 0 is the cell's own read bus, 1 is `gbus_in`, 2 is north, 3 is east, 4 is south, 5 is west, and 6 or 7 gives zero.
- R5: Opcode 2 loads the write bus into the accumulator, sets the zero flag (`flag_out[0]`) when that value is zero, and clears the carry flag (`flag_out[1]`).
- R6: Opcode 3 sets the accumulator to the accumulator minus the write bus, modulo 256. The carry flag is set when a borrow occurs (accumulator less than write bus), and the zero flag reflects the result.
- R7: Opcode 4 sets the accumulator to the accumulator plus the write bus, modulo 256. The carry flag is the carry out of the sum, and the zero flag reflects the result.
- R8: Opcode 5 loads `{wb[6:0], cin}` and opcode 6 loads `{cin, wb[7:1]}`, where `cin` is `instr[14]`, into destination registers 0 to 3 only. The carry flag takes the bit shifted out and the zero flag reflects the loaded value. A shift aimed at any other destination changes no state.
- R9: Opcode 7 sets the propagate flag (`flag_out[2]`) when the write bus is non-zero and clears it otherwise.
- R10: The condition field `instr[13:12]` works as follows: 0 executes always, while 1, 2 and 3 execute only when the zero, carry or propagate flag respectively is set. A skipped instruction changes no register, accumulator or flag.
- R11: With `instr_valid` low, no register, accumulator, flag or `gbus_out` changes.
- R12: One edge after a valid instruction, `gbus_out` holds the read-bus value that instruction presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Broadcast instruction is present this cycle |
| instr | input | 15 | Broadcast instruction word |
| gbus_in | input | 8 | Global input bus |
| nbr_n | input | 8 | North neighbour read bus |
| nbr_e | input | 8 | East neighbour read bus |
| nbr_s | input | 8 | South neighbour read bus |
| nbr_w | input | 8 | West neighbour read bus |
| lbus_out | output | 8 | Cell read bus, visible to neighbours |
| gbus_out | output | 8 | Registered read-bus value for the global bus |
| flag_out | output | 3 | Flags: bit 0 zero, bit 1 carry, bit 2 propagate |

## Verification
The read bus is combinational, so the bench compares `lbus_out` a short delay after driving an instruction's source field, before the edge that executes it. Register, accumulator and flag updates, and the `gbus_out` copy, are due at the first rising edge after the instruction is driven. The bench applies inputs on the falling edge and samples one time unit after the next rising edge. Registers and the accumulator are read back through the read bus with `instr_valid` low, which changes nothing. The expected values come from a bench-side model of the requirements, updated once per instruction.

// File: rtl/pxl_cell_pkg.sv
package pxl_cell_pkg;
  localparam int IW = 15;
  // instruction field positions
  localparam int RD_LSB   = 0;
  localparam int SRC_LSB  = 3;
  localparam int OP_LSB   = 6;
  localparam int DST_LSB  = 9;
  localparam int COND_LSB = 12;
  localparam int CIN_BIT  = 14;

  typedef enum logic [2:0] {
    OP_NOP = 3'd0, OP_MOV = 3'd1, OP_LDA = 3'd2, OP_SUB = 3'd3,
    OP_ADD = 3'd4, OP_SHL = 3'd5, OP_SHR = 3'd6, OP_PFL = 3'd7
  } op_e;

  typedef enum logic [2:0] {
    SRC_LOCAL = 3'd0, SRC_GLB = 3'd1, SRC_N = 3'd2, SRC_E = 3'd3,
    SRC_S = 3'd4, SRC_W = 3'd5, SRC_Z6 = 3'd6, SRC_Z7 = 3'd7
  } src_e;

  localparam int FZ = 0;
  localparam int FC = 1;
  localparam int FP = 2;
endpackage

// File: rtl/pxl_busctl.sv
module pxl_busctl #(
  parameter int DW = 8
) (
  input  logic [2:0]    src,
  input  logic [DW-1:0] local_rb,
  input  logic [DW-1:0] glb,
  input  logic [DW-1:0] n_rb,
  input  logic [DW-1:0] e_rb,
  input  logic [DW-1:0] s_rb,
  input  logic [DW-1:0] w_rb,
  output logic [DW-1:0] wb
);
  always_comb begin
    case (src)
      3'd0:    wb = local_rb;
      3'd1:    wb = glb;
      3'd2:    wb = n_rb;
      3'd3:    wb = e_rb;
      3'd4:    wb = s_rb;
      3'd5:    wb = w_rb;
      default: wb = '0;
    endcase
  end
endmodule

// File: rtl/pxl_alu.sv
module pxl_alu #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] acc,
  input  logic [DW-1:0] opnd,
  input  logic          do_add,
  output logic [DW-1:0] res,
  output logic          carry
);
  logic [DW-1:0] b_eff;
  logic [DW:0]   diff;

  // addition: a + b == a - ~b - 1 (mod 2^DW); borrow inverts to carry
  assign b_eff = do_add ? ~opnd : opnd;
  assign diff  = {1'b0, acc} - {1'b0, b_eff} - {{DW{1'b0}}, do_add};
  assign res   = diff[DW-1:0];
  assign carry = do_add ? ~diff[DW] : diff[DW];
endmodule

// File: rtl/pxl_shifter.sv
module pxl_shifter #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] din,
  input  logic          left,
  input  logic          cin,
  output logic [DW-1:0] dout,
  output logic          sh_out
);
  always_comb begin
    if (left) begin
      dout   = {din[DW-2:0], cin};
      sh_out = din[DW-1];
    end else begin
      dout   = {cin, din[DW-1:1]};
      sh_out = din[0];
    end
  end
endmodule

// File: rtl/pxl_regfile.sv
module pxl_regfile #(
  parameter int DW   = 8,
  parameter int NREG = 7,
  parameter int AW   = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_idx,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] mem [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        mem[i] <= '0;
      else if (wr_en && wr_idx == AW'(i))
        mem[i] <= wr_data;
    end
  end

  assign rd_data = (int'(rd_idx) < NREG) ? mem[rd_idx] : '0;
endmodule

// File: rtl/pxl_cell.sv
module pxl_cell
  import pxl_cell_pkg::*;
#(
  parameter int DW     = 8,
  parameter int NREG   = 7,
  parameter int NSHIFT = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          instr_valid,
  input  logic [IW-1:0] instr,
  input  logic [DW-1:0] gbus_in,
  input  logic [DW-1:0] nbr_n,
  input  logic [DW-1:0] nbr_e,
  input  logic [DW-1:0] nbr_s,
  input  logic [DW-1:0] nbr_w,
  output logic [DW-1:0] lbus_out,
  output logic [DW-1:0] gbus_out,
  output logic [2:0]    flag_out
);
  localparam int AW = 3;
  localparam logic [AW-1:0] ACC_CODE = AW'(NREG);
  localparam logic [AW-1:0] SH_LIM   = AW'(NSHIFT);

  logic [AW-1:0] rd_sel, dst;
  logic [2:0]    src, op_raw;
  logic [1:0]    cond;
  logic          cin;
  op_e           op;

  assign rd_sel = instr[RD_LSB +: AW];
  assign src    = instr[SRC_LSB +: 3];
  assign op_raw = instr[OP_LSB +: 3];
  assign op     = op_e'(op_raw);
  assign dst    = instr[DST_LSB +: AW];
  assign cond   = instr[COND_LSB +: 2];
  assign cin    = instr[CIN_BIT];

  logic [DW-1:0] acc_q, gbus_q, rf_rd, wb;
  logic [2:0]    flag_q;
  logic [DW-1:0] alu_res, sh_res;
  logic          alu_c, sh_c, cond_ok, go, sh_op, sh_ok, rf_we;

  // phase 1: read bus
  assign lbus_out = (rd_sel == ACC_CODE) ? acc_q : rf_rd;

  // phase 2: write bus selection
  pxl_busctl #(.DW(DW)) u_bus (
    .src(src), .local_rb(lbus_out), .glb(gbus_in),
    .n_rb(nbr_n), .e_rb(nbr_e), .s_rb(nbr_s), .w_rb(nbr_w), .wb(wb)
  );

  pxl_alu #(.DW(DW)) u_alu (
    .acc(acc_q), .opnd(wb), .do_add(op == OP_ADD), .res(alu_res), .carry(alu_c)
  );

  pxl_shifter #(.DW(DW)) u_sh (
    .din(wb), .left(op == OP_SHL), .cin(cin), .dout(sh_res), .sh_out(sh_c)
  );

  always_comb begin
    case (cond)
      2'd0:    cond_ok = 1'b1;
      2'd1:    cond_ok = flag_q[FZ];
      2'd2:    cond_ok = flag_q[FC];
      default: cond_ok = flag_q[FP];
    endcase
  end

  assign go    = instr_valid && cond_ok;
  assign sh_op = (op == OP_SHL) || (op == OP_SHR);
  assign sh_ok = sh_op && (dst < SH_LIM);
  assign rf_we = go && (((op == OP_MOV) && (dst != ACC_CODE)) || sh_ok);

  // phase 3: destination load
  pxl_regfile #(.DW(DW), .NREG(NREG), .AW(AW)) u_rf (
    .clk(clk), .rst(rst), .wr_en(rf_we), .wr_idx(dst),
    .wr_data((op == OP_MOV) ? wb : sh_res),
    .rd_idx(rd_sel), .rd_data(rf_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      flag_q <= '0;
      gbus_q <= '0;
    end else begin
      if (instr_valid) gbus_q <= lbus_out;
      if (go) begin
        case (op)
          OP_LDA: begin
            acc_q      <= wb;
            flag_q[FZ] <= (wb == '0);
            flag_q[FC] <= 1'b0;
          end
          OP_SUB, OP_ADD: begin
            acc_q      <= alu_res;
            flag_q[FZ] <= (alu_res == '0);
            flag_q[FC] <= alu_c;
          end
          OP_SHL, OP_SHR: begin
            if (sh_ok) begin
              flag_q[FZ] <= (sh_res == '0);
              flag_q[FC] <= sh_c;
            end
          end
          OP_PFL:  flag_q[FP] <= (wb != '0);
          default: ;
        endcase
      end
    end
  end

  assign gbus_out = gbus_q;
  assign flag_out = flag_q;
endmodule

// File: rtl/pxl_cell_chk.sv
module pxl_cell_chk
  import pxl_cell_pkg::*;
#(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          instr_valid,
  input logic [IW-1:0] instr,
  input logic [DW-1:0] gbus_in,
  input logic [DW-1:0] lbus_out,
  input logic [DW-1:0] gbus_out,
  input logic [2:0]    flag_out
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (flag_out == 3'b000) && (gbus_out == '0));

  // R12
  gbus_copy_chk: assert property (@(posedge clk) disable iff (rst)
    instr_valid |=> gbus_out == $past(lbus_out));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !instr_valid |=> $stable(flag_out) && $stable(gbus_out));

  // R10
  skip_on_clear_z_chk: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && instr[COND_LSB +: 2] == 2'd1 && !flag_out[FZ]) |=> $stable(flag_out));

  // R9
  prop_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && instr[COND_LSB +: 2] == 2'd0 && instr[OP_LSB +: 3] == 3'd7
     && instr[SRC_LSB +: 3] == 3'd1) |=> flag_out[FP] == ($past(gbus_in) != '0));
endmodule

bind pxl_cell pxl_cell_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr(instr),
  .gbus_in(gbus_in), .lbus_out(lbus_out), .gbus_out(gbus_out), .flag_out(flag_out)
);

// File: tb/pxl_cell_bench.sv
module pxl_cell_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instr_valid = 1'b0;
  logic [14:0] instr = '0;
  logic [7:0]  gbus_in = '0, nbr_n = '0, nbr_e = '0, nbr_s = '0, nbr_w = '0;
  logic [7:0]  lbus_out, gbus_out;
  logic [2:0]  flag_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] m_reg [7];
  logic [7:0] m_acc, m_gbo;
  logic [2:0] m_flag;

  always #4 clk = ~clk;

  pxl_cell u_pxl_cell (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr(instr),
    .gbus_in(gbus_in), .nbr_n(nbr_n), .nbr_e(nbr_e), .nbr_s(nbr_s), .nbr_w(nbr_w),
    .lbus_out(lbus_out), .gbus_out(gbus_out), .flag_out(flag_out)
  );

  function automatic logic [14:0] mk(int rd, int src, int op, int dst, int cond, int cin);
    return {cin[0], cond[1:0], dst[2:0], op[2:0], src[2:0], rd[2:0]};
  endfunction

  function automatic logic [7:0] m_rd(logic [2:0] k);
    return (k == 3'd7) ? m_acc : m_reg[k];
  endfunction

  function automatic logic [7:0] m_wb(logic [2:0] src, logic [2:0] rd);
    case (src)
      3'd0: return m_rd(rd);
      3'd1: return gbus_in;
      3'd2: return nbr_n;
      3'd3: return nbr_e;
      3'd4: return nbr_s;
      3'd5: return nbr_w;
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_step(logic [14:0] w, logic v);
    logic [2:0] rd, src, op, dst;
    logic [1:0] cond;
    logic cin, ok;
    logic [7:0] wb, r;
    logic [8:0] s;
    rd = w[2:0]; src = w[5:3]; op = w[8:6]; dst = w[11:9]; cond = w[13:12]; cin = w[14];
    if (!v) return;
    wb = m_wb(src, rd);
    m_gbo = m_rd(rd);
    ok = (cond == 2'd0) ? 1'b1 : m_flag[cond - 2'd1];
    if (!ok) return;
    case (op)
      3'd1: if (dst != 3'd7) m_reg[dst] = wb;
      3'd2: begin m_acc = wb; m_flag[0] = (wb == 0); m_flag[1] = 1'b0; end
      3'd3: begin
        m_flag[1] = (m_acc < wb); m_acc = m_acc - wb; m_flag[0] = (m_acc == 0);
      end
      3'd4: begin
        s = {1'b0, m_acc} + {1'b0, wb}; m_acc = s[7:0];
        m_flag[1] = s[8]; m_flag[0] = (m_acc == 0);
      end
      3'd5, 3'd6: if (dst < 3'd4) begin
        r = (op == 3'd5) ? {wb[6:0], cin} : {cin, wb[7:1]};
        m_flag[1] = (op == 3'd5) ? wb[7] : wb[0];
        m_reg[dst] = r; m_flag[0] = (r == 0);
      end
      3'd7: m_flag[2] = (wb != 0);
      default: ;
    endcase
  endtask

  // drive at falling edge, check read bus before the edge, state after it
  task automatic run(string tag, logic [14:0] w, logic v = 1'b1);
    @(negedge clk);
    instr = w; instr_valid = v;
    #1;
    chk({tag, " R2 read bus"}, lbus_out, m_rd(w[2:0]));
    model_step(w, v);
    @(posedge clk); #1;
    chk({tag, " flags"}, flag_out, m_flag);
    chk({tag, " R12 gbus_out"}, gbus_out, m_gbo);
    instr_valid = 1'b0;
  endtask

  task automatic peek(string tag, int k);
    @(negedge clk);
    instr_valid = 1'b0; instr = mk(k, 0, 0, 7, 0, 0);
    #1;
    chk(tag, lbus_out, m_rd(k[2:0]));
  endtask

  task automatic peek_all(string tag);
    for (int k = 0; k < 8; k++) peek(tag, k);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    for (int k = 0; k < 7; k++) m_reg[k] = '0;
    m_acc = '0; m_flag = '0; m_gbo = '0;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R1 reset state
    chk("R1 flags", flag_out, 3'b000);
    chk("R1 gbus_out", gbus_out, 8'h00);
    peek_all("R1 regs");

    // R4 / R3 sources into registers
    gbus_in = 8'h5A; nbr_n = 8'h11; nbr_e = 8'h22; nbr_s = 8'h33; nbr_w = 8'h44;
    run("R4 glb", mk(0, 1, 1, 0, 0, 0));
    run("R4 north", mk(0, 2, 1, 1, 0, 0));
    run("R4 east", mk(0, 3, 1, 2, 0, 0));
    run("R4 south", mk(0, 4, 1, 3, 0, 0));
    run("R4 west", mk(0, 5, 1, 4, 0, 0));
    run("R3 local", mk(0, 0, 1, 5, 0, 0));
    run("R4 zero", mk(0, 6, 1, 6, 0, 0));
    run("R3 no dest", mk(1, 1, 1, 7, 0, 0));
    peek_all("R3 regs");

    // R5 / R6 / R7 arithmetic
    run("R5 load", mk(1, 0, 2, 0, 0, 0));
    run("R5 load zero", mk(0, 7, 2, 0, 0, 0));
    gbus_in = 8'h10; run("R5 load glb", mk(0, 1, 2, 0, 0, 0));
    gbus_in = 8'h20; run("R6 borrow", mk(7, 1, 3, 0, 0, 0));
    chk("R6 acc", lbus_out, 8'hF0);
    gbus_in = 8'hF0; run("R6 to zero", mk(7, 1, 3, 0, 0, 0));
    run("R5 reload", mk(7, 1, 2, 0, 0, 0));
    gbus_in = 8'h20; run("R7 carry", mk(7, 1, 4, 0, 0, 0));
    chk("R7 acc", lbus_out, 8'h10);
    gbus_in = 8'h00; run("R7 no carry", mk(7, 1, 4, 0, 0, 0));

    // R8 shifts
    gbus_in = 8'h81;
    run("R8 shl", mk(0, 1, 5, 0, 0, 1));
    run("R8 shr", mk(0, 1, 6, 1, 0, 0));
    run("R8 non-shift dest", mk(0, 1, 5, 5, 0, 1));
    peek_all("R8 regs");

    // R9 propagate flag
    gbus_in = 8'h00; run("R9 clear", mk(0, 1, 7, 0, 0, 0));
    gbus_in = 8'h04; run("R9 set", mk(0, 1, 7, 0, 0, 0));

    // R10 conditional execution
    gbus_in = 8'h01; run("R10 Z clear", mk(0, 1, 2, 0, 0, 0));
    gbus_in = 8'h77; run("R10 skip", mk(0, 1, 1, 6, 1, 0));
    run("R10 skip acc", mk(0, 1, 2, 0, 1, 0));
    run("R10 on P", mk(0, 1, 1, 6, 3, 0));
    peek_all("R10 regs");

    // R11 invalid instruction
    gbus_in = 8'hEE; run("R11 idle", mk(3, 1, 1, 2, 0, 0), 1'b0);
    run("R11 idle acc", mk(3, 1, 4, 2, 0, 0), 1'b0);
    peek_all("R11 regs");

    // constrained random mix
    for (int i = 0; i < 600; i++) begin
      gbus_in = 8'($urandom); nbr_n = 8'($urandom); nbr_e = 8'($urandom);
      nbr_s = 8'($urandom); nbr_w = 8'($urandom);
      run("random", 15'($urandom), ($urandom % 8) != 0);
    end
    peek_all("random regs");
    finish_run();
  end
endmodule